// File: doc/BRIEF.md
# Instruction Fetch and Indirect Sequencer

This block is the control sequencer for the fetch side of a small accumulator-style processor. It holds a program counter, a memory address register, a memory data register and an instruction register. It fetches one instruction word at a time from a synchronous memory. The memory returns read data one clock after the read strobe. Each fetch is followed by a test of the indirect flag in the instruction. When the flag is set, a second read replaces the instruction's address field with the word found at that address. A one-clock execute strobe then hands the finished instruction to the execution stage, and the sequencer goes back to fetch.

An instruction word has three fields. The top `OPC_W` bits are the opcode. The next bit down is the indirect flag. The remaining `ADDR_W = DATA_W - OPC_W - 1` low bits are the address field. A halt input freezes the sequencer at the start of a fetch, and no register changes while it is held there.

Top module: `ifetch_seq`

## Requirements
- R1: While `rst_n` is low, `pc_out`, `mem_addr` and `ir_out` are all zero, and `mem_rd` and `exec_stb` are low. After reset is released, the first instruction fetched comes from address 0.
- R2: Each instruction begins with exactly one fetch read. In that read, `mem_rd` is high for one clock in the second cycle of the instruction, and `mem_addr` equals the program counter value at the start of the instruction.
- R3: The word returned on `mem_rdata` in the clock after a fetch read passes through the data register into the instruction register. For a direct instruction, `ir_out` equals that word unchanged when `exec_stb` is high.
- R4: Every fetch increments the program counter by exactly 1, modulo 2^ADDR_W. After the fetch, `pc_out` equals the fetch address plus one.
- R5: Bit `DATA_W-OPC_W-1` of the instruction word is the indirect flag. When that bit is 1, the instruction is indirect. Bits `DATA_W-1` down to `DATA_W-OPC_W` are the opcode, and bits `ADDR_W-1` down to 0 are the address field.
- R6: A direct instruction raises `exec_stb` in its 6th cycle. An indirect instruction raises `exec_stb` in its 10th cycle. The cycle count starts with the first cycle of the fetch.
- R7: An indirect instruction issues a second one-clock read whose `mem_addr` is the instruction's address field. The low `ADDR_W` bits of the returned word then replace the address field of the instruction register. The opcode and the flag bit are kept.
- R8: `exec_stb` is high for exactly one clock. The cycle after it is the first cycle of the next fetch, and `mem_rd` is low in that cycle.
- R9: `halt` is sampled only in the first cycle of a fetch. While it is high there, the sequencer stays in that cycle and issues no read, and `pc_out`, `ir_out` and `mem_addr` do not change. A high `halt` in any other cycle has no effect on the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Hold the sequencer at the start of the next fetch |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_rd | output | 1 | One-clock read strobe; memory answers on the next clock |
| mem_rdata | input | DATA_W | Read data from memory, valid one clock after `mem_rd` |
| exec_stb | output | 1 | One-clock strobe: the instruction register is ready to execute |
| pc_out | output | ADDR_W | Program counter, the address of the next instruction |
| ir_out | output | DATA_W | Instruction register, with the operand address resolved |

## Verification
A stuck or skipped state in the sequencer appears at once as a wrong cycle count between execute strobes: 6 for a direct instruction and 10 for an indirect one. It also appears as a missing or extra read strobe in that interval. A data-path fault, such as the address register loaded from the wrong source or the program counter failing to advance, shows on `mem_addr` during the first read of the next instruction. It shows on `ir_out` at the execute strobe within the same instruction. A halt that leaks past the first fetch cycle, or that disturbs a register, is visible within one clock as a read strobe or as a change on `pc_out`, `ir_out` or `mem_addr`.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  // One state per clock of the fetch / indirect / execute sequence.
  typedef enum logic [3:0] {
    ST_F_ADDR  = 4'd0,  // PC -> MAR, halt is sampled here
    ST_F_READ  = 4'd1,  // read strobe, PC advances
    ST_F_CAP   = 4'd2,  // data bus -> MBR
    ST_F_LOAD  = 4'd3,  // MBR -> IR
    ST_CHECK   = 4'd4,  // test the indirect flag
    ST_I_ADDR  = 4'd5,  // IR address field -> MAR
    ST_I_READ  = 4'd6,  // read strobe for the pointer word
    ST_I_CAP   = 4'd7,  // data bus -> MBR
    ST_I_MERGE = 4'd8,  // MBR low bits -> IR address field
    ST_EXEC    = 4'd9   // one-clock execute strobe
  } seq_state_t;

endpackage

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
  import ifs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic ind_flag,
  output logic ld_mar_pc,
  output logic ld_mar_ir,
  output logic inc_pc,
  output logic ld_mbr,
  output logic ld_ir_full,
  output logic ld_ir_addr,
  output logic rd_stb,
  output logic exec_stb,
  output logic fetch_start,
  output logic fetch_rd,
  output logic merge_evt
);

  seq_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_F_ADDR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    ld_mar_pc   = 1'b0;
    ld_mar_ir   = 1'b0;
    inc_pc      = 1'b0;
    ld_mbr      = 1'b0;
    ld_ir_full  = 1'b0;
    ld_ir_addr  = 1'b0;
    rd_stb      = 1'b0;
    exec_stb    = 1'b0;
    fetch_start = 1'b0;
    fetch_rd    = 1'b0;
    merge_evt   = 1'b0;
    case (state_q)
      ST_F_ADDR: begin
        fetch_start = 1'b1;
        if (!halt) begin
          ld_mar_pc = 1'b1;
          state_d   = ST_F_READ;
        end
      end
      ST_F_READ: begin
        rd_stb   = 1'b1;
        fetch_rd = 1'b1;
        inc_pc   = 1'b1;
        state_d  = ST_F_CAP;
      end
      ST_F_CAP: begin
        ld_mbr  = 1'b1;
        state_d = ST_F_LOAD;
      end
      ST_F_LOAD: begin
        ld_ir_full = 1'b1;
        state_d    = ST_CHECK;
      end
      ST_CHECK: begin
        state_d = ind_flag ? ST_I_ADDR : ST_EXEC;
      end
      ST_I_ADDR: begin
        ld_mar_ir = 1'b1;
        state_d   = ST_I_READ;
      end
      ST_I_READ: begin
        rd_stb  = 1'b1;
        state_d = ST_I_CAP;
      end
      ST_I_CAP: begin
        ld_mbr  = 1'b1;
        state_d = ST_I_MERGE;
      end
      ST_I_MERGE: begin
        ld_ir_addr = 1'b1;
        merge_evt  = 1'b1;
        state_d    = ST_EXEC;
      end
      ST_EXEC: begin
        exec_stb = 1'b1;
        state_d  = ST_F_ADDR;
      end
      default: state_d = ST_F_ADDR;
    endcase
  end

endmodule

// File: rtl/ifs_regs.sv
module ifs_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mar_pc,
  input  logic              ld_mar_ir,
  input  logic              inc_pc,
  input  logic              ld_mbr,
  input  logic              ld_ir_full,
  input  logic              ld_ir_addr,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] ir
);

  localparam int HEAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mbr;

  // Next program counter: wraps modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  // Address field of an instruction word.
  function automatic logic [ADDR_W-1:0] addr_of(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  // Keep opcode and flag, take the resolved address from the pointer word.
  function automatic logic [DATA_W-1:0] merge_addr(input logic [DATA_W-1:0] instr,
                                                   input logic [DATA_W-1:0] ptr);
    logic [HEAD_W-1:0] head;
    head = instr[DATA_W-1:ADDR_W];
    return {head, addr_of(ptr)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
    end else begin
      if (ld_mar_pc)      mar <= pc;
      else if (ld_mar_ir) mar <= addr_of(ir);
      if (inc_pc)         pc  <= pc_step(pc);
      if (ld_mbr)         mbr <= rdata;
      if (ld_ir_full)     ir  <= mbr;
      else if (ld_ir_addr) ir <= merge_addr(ir, mbr);
    end
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq #(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  localparam int ADDR_W = DATA_W - OPC_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              exec_stb,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] ir_out
);

  localparam int IND_BIT = ADDR_W;

  // Internal events, named so the bound checker can see them.
  logic              ld_mar_pc, ld_mar_ir, inc_pc, ld_mbr, ld_ir_full, ld_ir_addr;
  logic              fetch_start_w, fetch_rd_w, merge_evt_w;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q;

  ifs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .ind_flag    (ir_q[IND_BIT]),
    .ld_mar_pc   (ld_mar_pc),
    .ld_mar_ir   (ld_mar_ir),
    .inc_pc      (inc_pc),
    .ld_mbr      (ld_mbr),
    .ld_ir_full  (ld_ir_full),
    .ld_ir_addr  (ld_ir_addr),
    .rd_stb      (mem_rd),
    .exec_stb    (exec_stb),
    .fetch_start (fetch_start_w),
    .fetch_rd    (fetch_rd_w),
    .merge_evt   (merge_evt_w)
  );

  ifs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_mar_pc  (ld_mar_pc),
    .ld_mar_ir  (ld_mar_ir),
    .inc_pc     (inc_pc),
    .ld_mbr     (ld_mbr),
    .ld_ir_full (ld_ir_full),
    .ld_ir_addr (ld_ir_addr),
    .rdata      (mem_rdata),
    .pc         (pc_q),
    .mar        (mar_q),
    .ir         (ir_q)
  );

  assign mem_addr = mar_q;
  assign pc_out   = pc_q;
  assign ir_out   = ir_q;

endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt,
  input logic              mem_rd,
  input logic              exec_stb,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic              fetch_start,
  input logic              fetch_rd,
  input logic              merge_evt
);

  // R2: the fetch read targets the current program counter
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rd |-> (mem_rd && mem_addr == pc));

  // R4: program counter advances by one after a fetch read
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rd |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

  // R7: merging the pointer keeps opcode and flag
  assert_merge_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    merge_evt |=> $stable(ir[DATA_W-1:ADDR_W]));

  // R8: execute strobe lasts one clock and is followed by fetch start
  assert_exec_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> (!exec_stb && fetch_start && !mem_rd));

  // R8: read strobes never last two clocks
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R9: holding at fetch start changes nothing and issues no read
  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && halt) |=> (fetch_start && !mem_rd && $stable(pc) && $stable(ir)
                               && $stable(mem_addr)));

  // R9: no read is issued in the cycle where halt is sampled
  assert_start_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (!mem_rd && !exec_stb));

endmodule

bind ifetch_seq ifs_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt        (halt),
  .mem_rd      (mem_rd),
  .exec_stb    (exec_stb),
  .mem_addr    (mem_addr),
  .pc          (pc_q),
  .ir          (ir_q),
  .fetch_start (fetch_start_w),
  .fetch_rd    (fetch_rd_w),
  .merge_evt   (merge_evt_w)
);

// File: tb/ifetch_seq_test.sv
module ifetch_seq_test;

  localparam int DW    = 16;
  localparam int OW    = 4;
  localparam int AW    = DW - OW - 1;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 8;

  // Instruction words placed at addresses 0..7, and the cycle count expected for each.
  localparam logic [DW-1:0] VEC_WORD [NVEC] = '{
    16'h1005, 16'h2FFF, 16'hF800, 16'h0000, 16'hAC00, 16'h77FF, 16'h3A00, 16'hFFFF };
  localparam int VEC_CYC [NVEC] = '{ 6, 10, 10, 6, 10, 6, 10, 10 };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata = '0;
  logic          exec_stb;
  logic [AW-1:0] pc_out;
  logic [DW-1:0] ir_out;

  logic [DW-1:0] mem [DEPTH];
  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_pc = '0;

  always #5 clk = ~clk;

  ifetch_seq #(.DATA_W(DW), .OPC_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .exec_stb(exec_stb), .pc_out(pc_out), .ir_out(ir_out)
  );

  // Synchronous memory: data appears one clock after the read strobe.
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [DW-1:0] expect_ir(input logic [DW-1:0] w);
    logic [DW-1:0] ptr;
    if (!w[AW]) return w;
    ptr = mem[w[AW-1:0]];
    return {w[DW-1:AW], ptr[AW-1:0]};
  endfunction

  // Runs one instruction starting at the current negedge (its first cycle).
  task automatic run_one(input logic [DW-1:0] word, input int exp_cyc, input bit pulse_halt);
    int cyc = 0;
    int nrd = 0;
    logic [AW-1:0] a1 = '0;
    logic [AW-1:0] a2 = '0;
    logic [AW-1:0] pc0 = exp_pc;
    forever begin
      cyc++;
      halt = pulse_halt && cyc >= 2 && cyc <= 5;
      if (mem_rd) begin
        nrd++;
        if (nrd == 1) a1 = mem_addr; else a2 = mem_addr;
      end
      if (exec_stb || cyc > 40) break;
      @(negedge clk);
    end
    halt = 1'b0;
    exp_pc = pc0 + AW'(1);
    check(cyc == exp_cyc, "R6", "cycles to execute strobe", cyc, exp_cyc);
    check(ir_out == expect_ir(word), word[AW] ? "R7" : "R3", "ir at execute", ir_out, expect_ir(word));
    check(pc_out == exp_pc, "R4", "pc after fetch", pc_out, exp_pc);
    check(a1 == pc0, "R2", "fetch read address", a1, pc0);
    check(nrd == (word[AW] ? 2 : 1), "R5", "read strobes per instruction", nrd, word[AW] ? 2 : 1);
    if (word[AW]) check(a2 == word[AW-1:0], "R7", "pointer read address", a2, word[AW-1:0]);
    @(negedge clk);
    check(!exec_stb && !mem_rd, "R8", "strobes low after execute", {exec_stb, mem_rd}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 16'h9E37) ^ 16'h5A5A;
    for (int i = 0; i < NVEC; i++) mem[i] = VEC_WORD[i];

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pc_out == '0 && mem_addr == '0 && ir_out == '0, "R1", "registers in reset",
          {pc_out, ir_out}, 0);
    check(!mem_rd && !exec_stb, "R1", "strobes in reset", {mem_rd, exec_stb}, 0);
    rst_n = 1'b1;

    // Vector table: direct and indirect words, address-field extremes.
    for (int k = 0; k < NVEC; k++) run_one(VEC_WORD[k], VEC_CYC[k], 1'b0);

    // R9: halt held at fetch start freezes everything.
    begin
      logic [AW-1:0] a0;
      logic [DW-1:0] i0;
      bit moved = 1'b0;
      halt = 1'b1;
      a0 = mem_addr;
      i0 = ir_out;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (mem_rd || exec_stb || pc_out != exp_pc || ir_out != i0 || mem_addr != a0) moved = 1'b1;
      end
      check(!moved, "R9", "state while halted", moved, 0);
      halt = 1'b0;
    end
    run_one(mem[8], mem[8][AW] ? 10 : 6, 1'b0);

    // R9: halt raised outside the first fetch cycle is ignored.
    run_one(mem[9], mem[9][AW] ? 10 : 6, 1'b1);
    run_one(mem[10], mem[10][AW] ? 10 : 6, 1'b1);

    // R1: reset in mid-instruction, then restart from address 0.
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pc_out == '0 && ir_out == '0 && mem_addr == '0, "R1", "registers after second reset",
          {pc_out, ir_out}, 0);
    rst_n = 1'b1;
    exp_pc = '0;
    run_one(VEC_WORD[0], VEC_CYC[0], 1'b0);

    finish_run();
  end

endmodule